// File: doc/BRIEF.md
# Random-access buffer write sequencer

This block stores one data byte into the buffer RAM of an external controller. The controller is reached only through a byte-wide register port that sits behind a transceiver. A caller gives a start pulse with a 16-bit RAM address and a data byte. The block then runs three register writes on the port. The first two load the controller's RAM pointer, one byte at a time, into two adjacent pointer registers. The third puts the byte into the controller's data register. Every transaction waits for the transceiver's done pulse before the next one is issued. When the last transaction completes, the block sends one done pulse back to the caller.

The block remembers the last RAM address it used. Bit 15 of a legal buffer address is always clear, so an address with bit 15 set is taken as a sentinel: the write goes to the remembered address plus one. A caller that fills the buffer in order can therefore send a stream of sentinel writes and never has to track the pointer itself.

Top module: `rabuf_write_seq`

## Requirements
- R1: After reset, port_go and done are low and port_rw is high.
- R2: Each accepted start produces exactly three write transactions, in this order: register PTR_LO_REG (default 0x22) with target address bits 7:0, then register PTR_LO_REG+1 (0x23) with bits 15:8, then register DATA_REG (default 0x24) with the data byte.
- R3: port_rw is low in every cycle where port_go is high, and high in every other cycle.
- R4: port_go is a one-cycle pulse. A transaction is not issued until port_done has returned for the previous one.
- R5: done is a one-cycle pulse. It is raised in the cycle after port_done returns for the data-register transaction.
- R6: When addr bit 15 is 0, the target address is addr, and the stored pointer becomes addr.
- R7: When addr bit 15 is 1, the other address bits are ignored. The target is the stored pointer plus one, modulo 2^16, and that value becomes the new stored pointer.
- R8: Reset clears the stored pointer to 0, so the first sentinel write after reset targets address 0x0001.
- R9: addr and data are captured in the start cycle. Changing them while the sequence runs does not alter the writes.
- R10: A start pulse that arrives while a sequence is running is ignored. It produces no extra transactions and does not change the stored pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to write one byte |
| addr | input | 16 | Target RAM address; bit 15 set means "previous address plus one" |
| data | input | 8 | Byte to store |
| port_go | output | 1 | One-cycle transaction strobe to the transceiver |
| port_rw | output | 1 | Read/write line; low for a write |
| port_reg_addr | output | 8 | Controller register address for the transaction |
| port_wdata | output | 8 | Byte written to that register |
| port_done | input | 1 | One-cycle completion pulse from the transceiver |
| done | output | 1 | One-cycle completion pulse to the caller |

## Verification
A wrong stored pointer is not visible while it sits unused. It appears on port_wdata in the first pointer transaction of the next sentinel write, so the bench checks every run of sentinel writes address by address. It also checks across the low-byte carry and the 0x7FFF to 0x8000 step. A fault in the phase counter shows up within the same request: a transaction goes to the wrong register, arrives out of order, or is issued without waiting for port_done. A lost or duplicated transaction is caught through the write count and through the timing of done.

// File: rtl/rabuf_pkg.sv
package rabuf_pkg;
  typedef enum logic [0:0] {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } seq_state_e;
endpackage

// File: rtl/rabuf_ptr_track.sv
module rabuf_ptr_track #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addr_in,
  output logic [ADDR_W-1:0] resolved,
  output logic [ADDR_W-1:0] ptr_q
);
  localparam int SENT_BIT = ADDR_W - 1;

  // The sentinel bit selects the stored pointer plus one.
  always_comb begin
    if (addr_in[SENT_BIT]) resolved = ptr_q + ADDR_W'(1);
    else                   resolved = addr_in;
  end

  always_ff @(posedge clk) begin
    if (rst)       ptr_q <= '0;
    else if (load) ptr_q <= resolved;
  end

  // R7
  ptr_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (load && addr_in[SENT_BIT]) |=> (ptr_q == ADDR_W'($past(ptr_q) + ADDR_W'(1))));

  // R10
  ptr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(ptr_q));
endmodule

// File: rtl/rabuf_xact_seq.sv
module rabuf_xact_seq
  import rabuf_pkg::*;
#(
  parameter int                ADDR_W     = 16,
  parameter int                DW         = 8,
  parameter int                REG_AW     = 8,
  parameter logic [REG_AW-1:0] PTR_LO_REG = 8'h22,
  parameter logic [REG_AW-1:0] DATA_REG   = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] resolved,
  input  logic [ADDR_W-1:0] ptr_q,
  input  logic [DW-1:0]     data_in,
  output logic              accept,
  output logic              port_go,
  output logic              port_rw,
  output logic [REG_AW-1:0] port_reg_addr,
  output logic [DW-1:0]     port_wdata,
  input  logic              port_done,
  output logic              done
);
  localparam int NPTR  = ADDR_W / DW;
  localparam int NX    = NPTR + 1;
  localparam int PH_W  = $clog2(NX + 1);
  localparam logic [PH_W-1:0] LAST_PH = PH_W'(NX - 1);

  seq_state_e        state;
  logic [PH_W-1:0]   phase;
  logic [PH_W-1:0]   nph;
  logic [DW-1:0]     data_q;
  logic [DW-1:0]     ptr_byte [NPTR];
  logic [REG_AW-1:0] nxt_reg;
  logic [DW-1:0]     nxt_wdata;

  // Split the pointer into register-sized bytes, least significant first.
  for (genvar i = 0; i < NPTR; i++) begin : g_bytes
    assign ptr_byte[i] = ptr_q[i*DW +: DW];
  end

  assign accept = start && (state == ST_IDLE);
  assign nph    = phase + PH_W'(1);

  always_comb begin
    nxt_reg   = DATA_REG;
    nxt_wdata = data_q;
    for (int i = 1; i < NPTR; i++) begin
      if (nph == PH_W'(i)) begin
        nxt_reg   = PTR_LO_REG + REG_AW'(i);
        nxt_wdata = ptr_byte[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= ST_IDLE;
      phase         <= '0;
      data_q        <= '0;
      port_go       <= 1'b0;
      port_rw       <= 1'b1;
      port_reg_addr <= '0;
      port_wdata    <= '0;
      done          <= 1'b0;
    end else begin
      port_go <= 1'b0;
      port_rw <= 1'b1;
      done    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            data_q        <= data_in;
            phase         <= '0;
            port_go       <= 1'b1;
            port_rw       <= 1'b0;
            port_reg_addr <= PTR_LO_REG;
            port_wdata    <= resolved[DW-1:0];
            state         <= ST_WAIT;
          end
        end
        default: begin
          if (port_done) begin
            if (phase == LAST_PH) begin
              done  <= 1'b1;
              state <= ST_IDLE;
            end else begin
              phase         <= nph;
              port_go       <= 1'b1;
              port_rw       <= 1'b0;
              port_reg_addr <= nxt_reg;
              port_wdata    <= nxt_wdata;
            end
          end
        end
      endcase
    end
  end

  // R3
  go_rw_low_chk: assert property (@(posedge clk) disable iff (rst)
    port_go |-> !port_rw);

  // R4
  go_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    port_go |=> !port_go);

  // R4
  go_after_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !port_done) |=> !port_go);

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5
  done_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(port_done));
endmodule

// File: rtl/rabuf_write_seq.sv
module rabuf_write_seq #(
  parameter int         ADDR_W     = 16,
  parameter int         DW         = 8,
  parameter int         REG_AW     = 8,
  parameter logic [7:0] PTR_LO_REG = 8'h22,
  parameter logic [7:0] DATA_REG   = 8'h24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     data,
  output logic              port_go,
  output logic              port_rw,
  output logic [REG_AW-1:0] port_reg_addr,
  output logic [DW-1:0]     port_wdata,
  input  logic              port_done,
  output logic              done
);
  logic              accept;
  logic [ADDR_W-1:0] resolved;
  logic [ADDR_W-1:0] ptr_q;

  rabuf_ptr_track #(.ADDR_W(ADDR_W)) ptr_i (
    .clk      (clk),
    .rst      (rst),
    .load     (accept),
    .addr_in  (addr),
    .resolved (resolved),
    .ptr_q    (ptr_q)
  );

  rabuf_xact_seq #(
    .ADDR_W     (ADDR_W),
    .DW         (DW),
    .REG_AW     (REG_AW),
    .PTR_LO_REG (REG_AW'(PTR_LO_REG)),
    .DATA_REG   (REG_AW'(DATA_REG))
  ) seq_i (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .resolved      (resolved),
    .ptr_q         (ptr_q),
    .data_in       (data),
    .accept        (accept),
    .port_go       (port_go),
    .port_rw       (port_rw),
    .port_reg_addr (port_reg_addr),
    .port_wdata    (port_wdata),
    .port_done     (port_done),
    .done          (done)
  );

  // R3
  rw_idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !port_go |-> port_rw);
endmodule

// File: tb/rabuf_write_seq_tb.sv
module rabuf_write_seq_tb_top;
  localparam logic [7:0] LO_REG = 8'h22;
  localparam logic [7:0] HI_REG = 8'h23;
  localparam logic [7:0] DT_REG = 8'h24;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  data = '0;
  logic        port_go, port_rw, done;
  logic [7:0]  port_reg_addr, port_wdata;
  logic        port_done = 1'b0;

  int errors = 0;
  int checks = 0;
  int lat = 1;
  int cnt = 0;
  int m_step = 0;
  int nwr = 0;
  logic [7:0]  m_lo = '0, m_hi = '0;
  logic [15:0] last_addr = '0;
  logic [7:0]  last_data = '0;
  logic [15:0] exp_ptr = '0;

  always #5 clk = ~clk;

  rabuf_write_seq dut_i (
    .clk(clk), .rst(rst), .start(start), .addr(addr), .data(data),
    .port_go(port_go), .port_rw(port_rw), .port_reg_addr(port_reg_addr),
    .port_wdata(port_wdata), .port_done(port_done), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // Controller and transceiver model: register file plus delayed done.
  always @(posedge clk) begin
    port_done <= 1'b0;
    if (rst) begin
      cnt <= 0; m_step <= 0;
    end else if (port_go) begin
      chk(cnt == 0, "R4", "go before done", cnt, 0);
      chk(port_rw == 1'b0, "R3", "rw on go", int'(port_rw), 0);
      case (m_step)
        0: begin
          chk(port_reg_addr == LO_REG, "R2", "first reg", port_reg_addr, LO_REG);
          m_lo <= port_wdata; m_step <= 1;
        end
        1: begin
          chk(port_reg_addr == HI_REG, "R2", "second reg", port_reg_addr, HI_REG);
          m_hi <= port_wdata; m_step <= 2;
        end
        default: begin
          chk(port_reg_addr == DT_REG, "R2", "third reg", port_reg_addr, DT_REG);
          last_addr <= {m_hi, m_lo}; last_data <= port_wdata;
          nwr <= nwr + 1; m_step <= 0;
        end
      endcase
      cnt <= lat;
    end else if (cnt == 1) begin
      port_done <= 1'b1; cnt <= 0;
    end else if (cnt > 1) begin
      cnt <= cnt - 1;
    end
  end

  task automatic do_write(input logic [15:0] a, input logic [7:0] d,
                          input bit poke, input string tag);
    logic [15:0] exp;
    int n0;
    int k;
    exp = a[15] ? exp_ptr + 16'd1 : a;
    n0 = nwr;
    @(negedge clk); start = 1'b1; addr = a; data = d;
    @(negedge clk); start = 1'b0; addr = a ^ 16'h5A5A; data = ~d;  // R9
    if (poke) begin
      @(negedge clk); start = 1'b1; addr = 16'h1234; data = 8'hEE;   // R10
      @(negedge clk); start = 1'b0;
    end
    k = 0;
    while (done !== 1'b1 && k < 300) begin @(negedge clk); k++; end
    chk(done === 1'b1, "R5", "done seen", int'(done), 1);
    chk(last_addr == exp, tag, "target address", last_addr, exp);
    chk(last_data == d, "R9", "stored byte", last_data, d);
    chk(nwr == n0 + 1, "R10", "data writes per start", nwr - n0, 1);
    @(negedge clk);
    chk(done == 1'b0, "R5", "done width", int'(done), 0);
    chk(port_rw == 1'b1, "R3", "rw idle", int'(port_rw), 1);
    exp_ptr = exp;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL R4 watchdog: actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(port_go == 1'b0, "R1", "go after reset", int'(port_go), 0);
    chk(done == 1'b0, "R1", "done after reset", int'(done), 0);
    chk(port_rw == 1'b1, "R1", "rw after reset", int'(port_rw), 1);
    // R8: first sentinel after reset
    do_write(16'h8000, 8'hA5, 1'b0, "R8");
    // R6: explicit address sweep with varied transceiver latency
    for (int i = 0; i < 64; i++) begin
      lat = 1 + (i % 4);
      do_write(16'((i * 16'h0209) & 16'h7FFF), 8'(i * 7 + 3), 1'b0, "R6");
    end
    do_write(16'h0000, 8'h01, 1'b0, "R6");
    do_write(16'h7FFF, 8'h02, 1'b0, "R6");
    // R7: sentinel run across the low-byte carry
    do_write(16'h00F0, 8'h10, 1'b0, "R6");
    for (int i = 0; i < 40; i++) begin
      lat = 1 + (i % 3);
      do_write(16'(16'h8000 | (i * 16'h0123)), 8'(8'h40 + i), 1'b0, "R7");
    end
    // R7: increment past 0x7FFF
    do_write(16'h7FFE, 8'h20, 1'b0, "R6");
    do_write(16'hFFFF, 8'h21, 1'b0, "R7");
    do_write(16'h8000, 8'h22, 1'b0, "R7");
    do_write(16'h8ABC, 8'h23, 1'b0, "R7");
    // R10: start while busy is ignored, pointer kept
    lat = 3;
    do_write(16'h0345, 8'h11, 1'b1, "R6");
    do_write(16'h8000, 8'h12, 1'b0, "R10");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule